// File: doc/BRIEF.md
# Modulation RAM Update Sequencer

This block drives one synthesiser board that carries two direct digital synthesis (DDS) channels. Each channel has its own parameter RAM and its own block address counter. A timing controller sends two strobes. The first is an update strobe, active high. The second is a restart strobe, active low. Both channels act on a strobe in the same cycle and follow the same timing. Each channel reads only its own RAM.

On an update, the sequencer first pulses the shared I/O-update line. This commits the parameters that the DDS already holds in its input buffer. The sequencer then sends the next block from RAM over a bit-serial link, which uses a chip select, a serial clock and one data line per channel. The block address then moves to the following block. A restart sets the address back to zero and sends the first block, with no commit pulse. If both strobes arrive together, the sequencer issues one commit and sends one block, starting from address zero.

The block length comes from an input and is held within 2 to 11 bytes. A busy output covers the whole transfer. A strobe that arrives during a transfer is dropped and sets a sticky overrun flag.

Top module: `dds_update_seq`

## Requirements
- R1: An accepted update strobe (`upd_i` high while idle) makes `ioupd_o` high for exactly one cycle. That cycle is the first cycle after acceptance, the same cycle in which `cs_n_o` falls.
- R2: Each transfer sends `len` bytes. The bytes come from consecutive RAM addresses, starting at the current block address. Each byte is sent MSB first. `sdo_o` changes only when `sclk_o` falls and is read on the rising edge.
- R3: After a transfer is launched, the block address becomes start address + `len`. Back-to-back updates therefore send consecutive blocks.
- R4: A restart strobe (`restart_n_i` low while idle, `upd_i` low) sets the block address to 0 and sends the block at address 0. It never pulses `ioupd_o`. The next update then sends the block at address `len`.
- R5: When the update and restart strobes are accepted in the same cycle, there is one `ioupd_o` pulse and one transfer, and that transfer starts at address 0.
- R6: `cs_n_o` stays low for the whole frame, and `sclk_o` is low whenever it is idle. The first rising edge of `sclk_o` comes SETUP_CYC + HALF_DIV + 2 cycles after `cs_n_o` falls. Each bit lasts 2*HALF_DIV cycles.
- R7: `blk_len_i` is sampled when a strobe is accepted. A value below 2 is treated as 2, and a value above 11 is treated as 11.
- R8: `busy_o` is high from the first cycle after acceptance until `cs_n_o` rises again. A strobe that arrives while busy does not change the frame, the commit line or the address. It sets `overrun_o`, which stays set until reset.
- R9: Both channels use the same frame timing, and each sends the data from its own RAM.
- R10: After reset, `busy_o`, `ioupd_o`, `overrun_o` and `sclk_o` are low, `cs_n_o` is high, and the block address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_i | input | 1 | Update strobe, active high |
| restart_n_i | input | 1 | Restart strobe, active low |
| blk_len_i | input | LEN_W | Block length in bytes (held within 2 to 11) |
| ram_addr_o | output | NUM_CH*ADDR_W | RAM read address, one field per channel |
| ram_rdata_i | input | NUM_CH*8 | RAM read data, one-cycle read latency |
| ioupd_o | output | 1 | Commit pulse sent to both DDS channels |
| cs_n_o | output | 1 | Serial chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | NUM_CH | Serial data, one bit per channel |
| busy_o | output | 1 | High while a transfer is in progress |
| overrun_o | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The assertions check these rules on every cycle:
- A commit pulse always follows an update strobe.
- A restart alone never commits.
- A strobe that arrives while busy sets the overrun flag, and the flag stays set.
- The sampled length stays within range.
- A restart brings the read address back to zero.
- Every byte load moves the address forward by one.

Only the bench scenarios can show the rest:
- The order of bytes and bits on the wire for each channel.
- The walk across blocks from one update to the next.
- The single transfer when both strobes coincide.
- The exact setup delay and bit period.
- That a dropped strobe changes no frame, commit or address.

// File: rtl/dds_seq_pkg.sv
// Package: shared types for the modulation RAM update sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dds_seq_pkg;

    // Sequencer phases: idle, RAM read issue, first byte load,
    // chip-select setup, bit shifting.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOAD  = 3'd2,
        ST_SETUP = 3'd3,
        ST_SHIFT = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dds_seq_ctrl.sv
// Module: dds_seq_ctrl
// Shared frame controller. It accepts the update and restart strobes while
// idle, issues the commit pulse, clamps the block length, and times the
// serial frame: one RAM fetch, chip-select setup, then 8 bits per byte at
// 2*HALF_DIV clocks per bit. A strobe that arrives while busy is dropped
// and sets a sticky overrun flag.
// Assumes: the RAM has a one-cycle read latency; HALF_DIV >= 1; SETUP_CYC >= 1.
module dds_seq_ctrl
    import dds_seq_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int MIN_BYTES = 2,
    parameter int MAX_BYTES = 11,
    parameter int HALF_DIV  = 2,
    parameter int SETUP_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic             restart_n_i,
    input  logic [LEN_W-1:0] blk_len_i,
    output logic             launch_o,
    output logic             from_zero_o,
    output logic [LEN_W-1:0] len_next_o,
    output logic             load_first_o,
    output logic             load_next_o,
    output logic             shift_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             ioupd_o,
    output logic             overrun_o
);
    localparam int PH_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam int SU_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * HALF_DIV - 1);
    localparam logic [PH_W-1:0]  PH_HIGH = PH_W'(HALF_DIV);
    localparam logic [SU_W-1:0]  SU_LAST = SU_W'(SETUP_CYC - 1);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BYTES);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

    seq_state_e       state;
    logic [PH_W-1:0]  ph;
    logic [2:0]       bitc;
    logic [LEN_W-1:0] bytec;
    logic [LEN_W-1:0] len_q;
    logic [SU_W-1:0]  su;
    logic             ioupd_q;
    logic             ovr_q;
    logic             strobe;
    logic             accept;
    logic             bit_end;
    logic             last_byte;

    // Strobe decode and acceptance.
    always_comb begin
        strobe      = upd_i | ~restart_n_i;
        busy_o      = (state != ST_IDLE);
        accept      = strobe & ~busy_o;
        launch_o    = accept;
        from_zero_o = ~restart_n_i;
    end

    // Hold the requested length within the legal byte range.
    always_comb begin
        if (blk_len_i < LEN_MIN)      len_next_o = LEN_MIN;
        else if (blk_len_i > LEN_MAX) len_next_o = LEN_MAX;
        else                          len_next_o = blk_len_i;
    end

    // Decode the serial strobes for the lanes and the link pins.
    always_comb begin
        bit_end      = (state == ST_SHIFT) && (ph == PH_LAST);
        last_byte    = (bytec == len_q - 1'b1);
        load_first_o = (state == ST_LOAD);
        load_next_o  = bit_end && (bitc == 3'd7) && !last_byte;
        shift_o      = bit_end && (bitc != 3'd7);
        cs_n_o       = (state == ST_IDLE);
        sclk_o       = (state == ST_SHIFT) && (ph >= PH_HIGH);
        ioupd_o      = ioupd_q;
        overrun_o    = ovr_q;
    end

    // Commit pulse and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ioupd_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            ioupd_q <= accept & upd_i;
            if (strobe && busy_o) ovr_q <= 1'b1;
        end
    end

    // Frame sequencing: fetch, load, setup, then bit and byte counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            len_q <= LEN_MIN;
            ph    <= '0;
            bitc  <= '0;
            bytec <= '0;
            su    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        len_q <= len_next_o;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD: begin
                    su    <= '0;
                    state <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (su == SU_LAST) begin
                        ph    <= '0;
                        bitc  <= '0;
                        bytec <= '0;
                        state <= ST_SHIFT;
                    end else begin
                        su <= su + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (ph == PH_LAST) begin
                        ph <= '0;
                        if (bitc == 3'd7) begin
                            bitc <= '0;
                            if (last_byte) state <= ST_IDLE;
                            else           bytec <= bytec + 1'b1;
                        end else begin
                            bitc <= bitc + 1'b1;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a commit pulse only ever follows an update strobe.
    assert_commit_follows_update_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ioupd_o |-> $past(upd_i));

    // R4: a restart accepted alone never commits.
    assert_restart_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !restart_n_i && !upd_i) |=> !ioupd_o);

    // R8: a strobe that arrives while busy raises the overrun flag.
    assert_busy_strobe_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (upd_i || !restart_n_i)) |=> overrun_o);

    // R8: once set, the overrun flag stays set until reset.
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R7: while a transfer runs, the sampled length stays in range.
    assert_len_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (len_q >= LEN_MIN && len_q <= LEN_MAX));

endmodule

// File: rtl/dds_ser_lane.sv
// Module: dds_ser_lane
// Per-channel datapath. It holds the block address counter and the RAM read
// pointer, and shifts the current byte out MSB first. On launch the pointer
// starts at the block address (or at zero on a restart), and the block
// address moves on by the block length.
// Assumes: the RAM returns data one cycle after the address; control strobes
// come from dds_seq_ctrl.
module dds_ser_lane #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              from_zero_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              load_first_i,
    input  logic              load_next_i,
    input  logic              shift_i,
    input  logic [7:0]        rdata_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              sdo_o
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] start;
    logic [7:0]        shreg;

    // Choose where the new block starts.
    always_comb begin
        start      = from_zero_i ? '0 : base_q;
        ram_addr_o = rd_ptr;
        sdo_o      = shreg[7];
    end

    // Block address counter and RAM read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            rd_ptr <= '0;
        end else if (launch_i) begin
            rd_ptr <= start;
            base_q <= start + ADDR_W'(len_i);
        end else if (load_first_i || load_next_i) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Output shift register, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_first_i || load_next_i) begin
            shreg <= rdata_i;
        end else if (shift_i) begin
            shreg <= {shreg[6:0], 1'b0};
        end
    end

    // R4: a restart launch points the read address at zero.
    assert_restart_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && from_zero_i) |=> (ram_addr_o == '0));

    // R2: every byte load moves the read address forward by one.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_first_i || load_next_i) |=> (ram_addr_o == $past(ram_addr_o) + 1'b1));

endmodule

// File: rtl/dds_update_seq.sv
// Module: dds_update_seq (top)
// Update sequencer for one board that serves NUM_CH DDS channels. A single
// controller times the commit pulse and the serial frame. One lane per
// channel reads that channel's RAM and shifts its data out.
// Assumes: one synchronous-read RAM per channel outside the block; strobes
// are synchronous to clk.
module dds_update_seq #(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 4,
    parameter int HALF_DIV  = 2,
    parameter int SETUP_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_i,
    input  logic                     restart_n_i,
    input  logic [LEN_W-1:0]         blk_len_i,
    output logic [NUM_CH*ADDR_W-1:0] ram_addr_o,
    input  logic [NUM_CH*8-1:0]      ram_rdata_i,
    output logic                     ioupd_o,
    output logic                     cs_n_o,
    output logic                     sclk_o,
    output logic [NUM_CH-1:0]        sdo_o,
    output logic                     busy_o,
    output logic                     overrun_o
);
    logic             launch;
    logic             from_zero;
    logic [LEN_W-1:0] len_next;
    logic             load_first;
    logic             load_next;
    logic             shift;

    dds_seq_ctrl #(
        .LEN_W    (LEN_W),
        .MIN_BYTES(2),
        .MAX_BYTES(11),
        .HALF_DIV (HALF_DIV),
        .SETUP_CYC(SETUP_CYC)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (upd_i),
        .restart_n_i (restart_n_i),
        .blk_len_i   (blk_len_i),
        .launch_o    (launch),
        .from_zero_o (from_zero),
        .len_next_o  (len_next),
        .load_first_o(load_first),
        .load_next_o (load_next),
        .shift_o     (shift),
        .cs_n_o      (cs_n_o),
        .sclk_o      (sclk_o),
        .busy_o      (busy_o),
        .ioupd_o     (ioupd_o),
        .overrun_o   (overrun_o)
    );

    // One lane per DDS channel, each with its own RAM port and counter.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        dds_ser_lane #(
            .ADDR_W(ADDR_W),
            .LEN_W (LEN_W)
        ) i_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .launch_i    (launch),
            .from_zero_i (from_zero),
            .len_i       (len_next),
            .load_first_i(load_first),
            .load_next_i (load_next),
            .shift_i     (shift),
            .rdata_i     (ram_rdata_i[ch*8 +: 8]),
            .ram_addr_o  (ram_addr_o[ch*ADDR_W +: ADDR_W]),
            .sdo_o       (sdo_o[ch])
        );
    end

endmodule

// File: tb/test_dds_update_seq.sv
// Directed bench for dds_update_seq. Each task drives one scenario and
// checks its own results against values derived from the requirements.
module test_dds_update_seq;
    localparam int NUM_CH    = 2;
    localparam int ADDR_W    = 8;
    localparam int LEN_W     = 4;
    localparam int HALF_DIV  = 2;
    localparam int SETUP_CYC = 3;
    localparam int TCLK      = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     upd_i = 1'b0;
    logic                     restart_n_i = 1'b1;
    logic [LEN_W-1:0]         blk_len_i = 4'd4;
    logic [NUM_CH*ADDR_W-1:0] ram_addr_o;
    logic [NUM_CH*8-1:0]      ram_rdata_i = '0;
    logic                     ioupd_o, cs_n_o, sclk_o, busy_o, overrun_o;
    logic [NUM_CH-1:0]        sdo_o;

    int nchecks = 0;
    int nfails  = 0;
    bit done    = 1'b0;

    always #(TCLK/2) clk = ~clk;

    dds_update_seq #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .HALF_DIV(HALF_DIV), .SETUP_CYC(SETUP_CYC)
    ) i_dds_update_seq (
        .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .restart_n_i(restart_n_i),
        .blk_len_i(blk_len_i), .ram_addr_o(ram_addr_o), .ram_rdata_i(ram_rdata_i),
        .ioupd_o(ioupd_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
        .busy_o(busy_o), .overrun_o(overrun_o)
    );

    // RAM contents per channel, computed from the channel and the address.
    function automatic logic [7:0] ram_val(int ch, int a);
        return 8'((a * 37 + ch * 101 + 19) & 255);
    endfunction

    // Synchronous-read RAM model, one per channel.
    always @(posedge clk)
        for (int ch = 0; ch < NUM_CH; ch++)
            ram_rdata_i[ch*8 +: 8] <= ram_val(ch, int'(ram_addr_o[ch*ADDR_W +: ADDR_W]));

    // Link monitor: gathers bits on rising sclk and counts frames and commits.
    logic [7:0] acc [NUM_CH];
    logic [7:0] cap [NUM_CH][16];
    int  nbits = 0, frames = 0, commits = 0, busy_err = 0;
    time cs_fall_t = 0, rise1_t = 0, rise2_t = 0, ioupd_t = 0;

    always @(negedge cs_n_o) begin
        nbits = 0; cs_fall_t = $time;
    end
    always @(posedge cs_n_o) frames++;
    always @(posedge ioupd_o) ioupd_t = $time;
    always @(posedge sclk_o) begin
        nbits++;
        if (nbits == 1) rise1_t = $time;
        if (nbits == 2) rise2_t = $time;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            acc[ch] = {acc[ch][6:0], sdo_o[ch]};
            if (nbits % 8 == 0 && nbits / 8 <= 16) cap[ch][nbits/8-1] = acc[ch];
        end
    end
    always @(posedge clk) begin
        if (ioupd_o) commits++;
        if (!cs_n_o && !busy_o) busy_err++;
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one strobe cycle from the falling edge.
    task automatic strobe(bit u, bit r, int len);
        @(negedge clk);
        blk_len_i   = LEN_W'(len);
        upd_i       = u;
        restart_n_i = ~r;
        @(negedge clk);
        upd_i       = 1'b0;
        restart_n_i = 1'b1;
    endtask

    task automatic wait_frames(int target, string req);
        int n = 0;
        while (frames < target && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(frames >= target, req, frames, target);
        repeat (4) @(negedge clk);
    endtask

    // Run one strobe and compare the frame of every channel.
    task automatic frame_check(bit u, bit r, int len, int start, int nbytes,
                               int ncommit, string req);
        int f0 = frames;
        int c0 = commits;
        strobe(u, r, len);
        wait_frames(f0 + 1, req);
        check(frames == f0 + 1, {req, " single frame"}, frames - f0, 1);
        check(nbits == 8 * nbytes, {req, " bit count"}, nbits, 8 * nbytes);
        check(commits - c0 == ncommit, {req, " commit pulses"}, commits - c0, ncommit);
        for (int ch = 0; ch < NUM_CH; ch++)
            for (int i = 0; i < nbytes && i < 16; i++)
                check(cap[ch][i] == ram_val(ch, start + i), {req, " R9 byte"},
                      cap[ch][i], ram_val(ch, start + i));
    endtask

    task automatic test_reset();
        check(busy_o == 1'b0, "R10 busy", busy_o, 0);
        check(cs_n_o == 1'b1, "R10 cs_n", cs_n_o, 1);
        check(ioupd_o == 1'b0, "R10 ioupd", ioupd_o, 0);
        check(overrun_o == 1'b0, "R10 overrun", overrun_o, 0);
        check(sclk_o == 1'b0, "R10 sclk", sclk_o, 0);
        check(ram_addr_o == '0, "R10 address", ram_addr_o, 0);
    endtask

    task automatic test_update_walk();
        frame_check(1, 0, 4, 0, 4, 1, "R2 first block");
        check(ioupd_t == cs_fall_t, "R1 commit cycle", ioupd_t, cs_fall_t);
        check(rise1_t - cs_fall_t == (SETUP_CYC + HALF_DIV + 2) * TCLK, "R6 setup",
              rise1_t - cs_fall_t, (SETUP_CYC + HALF_DIV + 2) * TCLK);
        check(rise2_t - rise1_t == 2 * HALF_DIV * TCLK, "R6 bit period",
              rise2_t - rise1_t, 2 * HALF_DIV * TCLK);
        check(sclk_o == 1'b0 && cs_n_o == 1'b1, "R6 idle link", sclk_o, 0);
        frame_check(1, 0, 4, 4, 4, 1, "R3 next block");
        check(busy_err == 0, "R8 busy covers frame", busy_err, 0);
    endtask

    task automatic test_restart();
        frame_check(0, 1, 4, 0, 4, 0, "R4 restart");
        frame_check(1, 0, 4, 4, 4, 1, "R4 update after restart");
    endtask

    task automatic test_coincident();
        frame_check(1, 1, 4, 0, 4, 1, "R5 coincident");
    endtask

    task automatic test_len_clamp();
        frame_check(0, 1, 0, 0, 2, 0, "R7 short clamp");
        frame_check(1, 0, 15, 2, 11, 1, "R7 long clamp");
    endtask

    task automatic test_overrun();
        int f0, c0;
        frame_check(0, 1, 3, 0, 3, 0, "R8 pre");
        check(overrun_o == 1'b0, "R8 flag clear", overrun_o, 0);
        f0 = frames;
        c0 = commits;
        strobe(0, 1, 3);
        repeat (10) @(negedge clk);
        strobe(1, 0, 9);
        wait_frames(f0 + 1, "R8 frame");
        repeat (200) @(negedge clk);
        check(frames == f0 + 1, "R8 dropped strobe frames", frames - f0, 1);
        check(nbits == 24, "R8 frame length", nbits, 24);
        check(commits == c0, "R8 dropped strobe commit", commits - c0, 0);
        check(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
        frame_check(1, 0, 3, 3, 3, 1, "R8 address unaffected");
        check(overrun_o == 1'b1, "R8 overrun sticky", overrun_o, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        frames  = 0;
        commits = 0;
        test_reset();
        test_update_walk();
        test_restart();
        test_coincident();
        test_len_clamp();
        test_overrun();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nfails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
            $finish;
        end
    end

endmodule